// File: doc/BRIEF.md
# Global-History Correlating Direction Predictor

This block predicts whether a conditional branch will be taken. A short shift register keeps the resolved directions of the most recent branches anywhere in the program. A few low bits of the branch address pick an address set. The global history then picks one of several 2-bit saturating counters inside that set. The upper bit of the chosen counter is the prediction.

The fetch side presents a lookup PC and reads the prediction in the same cycle, with no register on the path. When a branch resolves, the execute side presents its PC and actual direction with a valid strobe. On that clock edge the counter picked by the address bits and the current history is trained. After that, the outcome is shifted into the history.

The history length, the number of address bits and the position of the lowest address bit used are all parameters. With zero history bits the block becomes a plain per-address table of 2-bit counters. The default holds 1024 counters: 8 address bits and 2 history bits.

Top module: `bp_gcorr_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds weakly not-taken (1), so every lookup predicts not-taken.
- R2: The table index is {PC[PC_LSB+ADDR_W-1:PC_LSB], history}. The address bits are the upper field and the history is the low field. The prediction is bit 1 of the indexed counter, so counter values 2 and 3 predict taken.
- R3: A taken update increments the selected counter. The counter stops at 3.
- R4: A not-taken update decrements the selected counter. The counter stops at 0.
- R5: An update changes only the counter chosen by the update PC together with the history in effect before that edge. Counters for the same address under other history values keep their values.
- R6: On each update the history shifts one place toward its upper bit. The outcome enters bit 0 (1 = taken) and the oldest outcome drops out.
- R7: PC bits outside the selected address field have no effect, so PCs that share the field share counters.
- R8: While the update strobe is low, neither the counters nor the history change, whatever the other update inputs carry.
- R9: The prediction is combinational from the lookup PC. An update in the same cycle is first seen after the clock edge.
- R10: With HIST_W = 0 the index is only the address field, and the block behaves as a per-address 2-bit counter table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_pc_i | input | PC_W | PC of the branch being fetched |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | A resolved branch is being reported |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual direction of the resolved branch, 1 = taken |

## Verification
The assertions assume that the update inputs are meaningful only while the strobe is high. They also assume that at most one branch resolves per cycle, in program order, so the history seen at an update is the history that was in effect when that branch was predicted. The stimulus reports at most one update per cycle and often changes the PC and direction inputs while the strobe is low. It reuses a small set of PCs, including aliasing pairs, so that the same sets are trained under every history value. A second instance with no history runs on the same stimulus to cover the plain-table variant.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr_e;

  function automatic ctr_e ctr_train(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    unique case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
      default: nxt = CTR_WNT;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter int HIST_W = 2,
  parameter int HW_EFF = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              taken_i,
  output logic [HW_EFF-1:0] hist_o
);
  generate
    if (HIST_W == 0) begin : g_none
      logic unused_in;
      assign unused_in = clk_i ^ rst_ni ^ shift_i ^ taken_i;
      assign hist_o = '0;
    end else if (HIST_W == 1) begin : g_one
      logic hist_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= 1'b0;
        else if (shift_i) hist_q <= taken_i;
      end
      assign hist_o = hist_q;
    end else begin : g_multi
      logic [HIST_W-1:0] hist_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      hist_q <= '0;
        else if (shift_i) hist_q <= {hist_q[HIST_W-2:0], taken_i};
      end
      assign hist_o = hist_q;
    end
  endgenerate
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_e             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i,
  output ctr_e             wr_old_o,
  output ctr_e             wr_new_o
);
  ctr_e tbl_q [DEPTH];

  assign rd_ctr_o = tbl_q[rd_idx_i];
  assign wr_old_o = tbl_q[wr_idx_i];
  assign wr_new_o = ctr_train(wr_old_o, wr_taken_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= CTR_WNT;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= wr_new_o;
    end
  end
endmodule

// File: rtl/bp_gcorr_predictor.sv
module bp_gcorr_predictor
  import bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int ADDR_W = 8,
  parameter int HIST_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lookup_pc_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int HW_EFF = (HIST_W > 0) ? HIST_W : 1;
  localparam int IDX_W  = ADDR_W + HIST_W;
  localparam int DEPTH  = 1 << IDX_W;

  logic [HW_EFF-1:0] hist;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  ctr_e              rd_ctr, wr_old_e, wr_new_e;
  logic [1:0]        wr_old, wr_new;
  logic              unused_pc;

  assign unused_pc = ^{lookup_pc_i, upd_pc_i};

  bp_history #(.HIST_W(HIST_W), .HW_EFF(HW_EFF)) u_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (upd_valid_i),
    .taken_i (upd_taken_i),
    .hist_o  (hist)
  );

  generate
    if (HIST_W == 0) begin : g_idx_flat
      assign rd_idx = lookup_pc_i[PC_LSB +: ADDR_W];
      assign wr_idx = upd_pc_i[PC_LSB +: ADDR_W];
    end else begin : g_idx_hist
      // address set in upper field, history picks the counter within it
      assign rd_idx = {lookup_pc_i[PC_LSB +: ADDR_W], hist};
      assign wr_idx = {upd_pc_i[PC_LSB +: ADDR_W], hist};
    end
  endgenerate

  bp_ctr_table #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_ctr_o   (rd_ctr),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (wr_idx),
    .wr_taken_i (upd_taken_i),
    .wr_old_o   (wr_old_e),
    .wr_new_o   (wr_new_e)
  );

  assign wr_old       = wr_old_e;
  assign wr_new       = wr_new_e;
  assign pred_taken_o = rd_ctr[1];
endmodule

// File: rtl/bp_gcorr_chk.sv
module bp_gcorr_chk #(
  parameter int HIST_W = 2,
  parameter int HW_EFF = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_valid_i,
  input logic              upd_taken_i,
  input logic [HW_EFF-1:0] hist_i,
  input logic [1:0]        wr_old_i,
  input logic [1:0]        wr_new_i,
  input logic              pred_taken_o
);
  // R8
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(hist_i));

  generate
    if (HIST_W > 0) begin : g_h
      // R6
      hist_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_i |=> hist_i[0] == $past(upd_taken_i));
    end
  endgenerate

  // R3
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_taken_i && wr_old_i == 2'd3 |-> wr_new_i == 2'd3);

  // R4
  sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_taken_i && wr_old_i == 2'd0 |-> wr_new_i == 2'd0);

  // R3
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_taken_i && wr_old_i != 2'd3 |-> wr_new_i == wr_old_i + 2'd1);

  // R4
  step_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_taken_i && wr_old_i != 2'd0 |-> wr_new_i == wr_old_i - 2'd1);

  // R2
  pred_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(pred_taken_o));
endmodule

bind bp_gcorr_predictor bp_gcorr_chk #(.HIST_W(HIST_W), .HW_EFF(HW_EFF)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .upd_valid_i  (upd_valid_i),
  .upd_taken_i  (upd_taken_i),
  .hist_i       (hist),
  .wr_old_i     (wr_old),
  .wr_new_i     (wr_new),
  .pred_taken_o (pred_taken_o)
);

// File: tb/tb_bp_gcorr_predictor.sv
`timescale 1ns/1ps
module tb_bp_gcorr_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lookup_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        pred, pred0;

  int errors = 0;
  int checks = 0;
  int m2 [1024];
  int m0 [256];
  int hist = 0;

  always #10 clk = ~clk;

  bp_gcorr_predictor dut (
    .clk_i(clk), .rst_ni(rst_n), .lookup_pc_i(lookup_pc), .pred_taken_o(pred),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken));

  bp_gcorr_predictor #(.HIST_W(0)) dut0 (
    .clk_i(clk), .rst_ni(rst_n), .lookup_pc_i(lookup_pc), .pred_taken_o(pred0),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken));

  function automatic int aset(input logic [31:0] pc);
    return int'((pc >> 2) & 32'hff);
  endfunction

  function automatic int train(input int c, input logic t);
    if (t) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  task automatic step(input logic [31:0] lpc, input logic uv, input logic [31:0] upc,
                      input logic ut, input string req);
    int e2, e0, wi;
    @(negedge clk);
    lookup_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    #1;
    e2 = (m2[(aset(lpc) << 2) | hist] >= 2) ? 1 : 0;
    e0 = (m0[aset(lpc)] >= 2) ? 1 : 0;
    checks++;
    if (int'(pred) != e2) begin
      errors++;
      $display("FAIL %s pc=%h hist=%0d actual=%0d expected=%0d", req, lpc, hist, pred, e2);
    end
    checks++;
    if (int'(pred0) != e0) begin
      errors++;
      $display("FAIL R10 (%s) pc=%h actual=%0d expected=%0d", req, lpc, pred0, e0);
    end
    if (uv) begin
      wi = (aset(upc) << 2) | hist;
      m2[wi] = train(m2[wi], ut);
      m0[aset(upc)] = train(m0[aset(upc)], ut);
      hist = ((hist << 1) | int'(ut)) & 3;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pcs [8];
    for (int i = 0; i < 1024; i++) m2[i] = 1;
    for (int i = 0; i < 256; i++) m0[i] = 1;
    pcs[0] = 32'h40; pcs[1] = 32'h44; pcs[2] = 32'h1040; pcs[3] = 32'h3fc;
    pcs[4] = 32'h800; pcs[5] = 32'h404; pcs[6] = 32'h10; pcs[7] = 32'h8a0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 8; i++) step(pcs[i], 1'b0, 32'h0, 1'b1, "R1");
    // R3 saturate taken
    for (int i = 0; i < 8; i++) step(32'h40, 1'b1, 32'h40, 1'b1, "R3");
    step(32'h40, 1'b0, 32'h0, 1'b0, "R3");
    // R7 aliasing PCs share counters
    step(32'h440, 1'b0, 32'h0, 1'b0, "R7");
    step(32'hffff0040, 1'b0, 32'h0, 1'b0, "R7");
    // R4 saturate not-taken
    for (int i = 0; i < 8; i++) step(32'h44, 1'b1, 32'h44, 1'b0, "R4");
    step(32'h44, 1'b0, 32'h0, 1'b0, "R4");
    // R5/R6 alternating pattern: history separates contexts of one address
    for (int i = 0; i < 16; i++) step(32'h80, 1'b1, 32'h80, i[0], "R5");
    for (int i = 0; i < 12; i++) step(32'h80, 1'b1, 32'h80, (i % 3) == 0, "R6");
    // R8 strobe low, other update inputs toggling
    for (int i = 0; i < 12; i++) step(pcs[i % 8], 1'b0, pcs[(i + 3) % 8], i[0], "R8");
    // R9 same-cycle lookup and update of the same branch
    for (int i = 0; i < 10; i++) step(32'h3fc, 1'b1, 32'h3fc, 1'b1, "R9");
    // R2 mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int a, b;
      a = $urandom_range(0, 7); b = $urandom_range(0, 7);
      step(pcs[a], ($urandom_range(0, 3) != 0), pcs[b], ($urandom_range(0, 2) != 0), "R2");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule